// File: doc/BRIEF.md
# Two-Wire Register-File Target

This block is a target on a two-wire serial bus (I2C). It gives a bus master access to a byte-wide register bank of 64 entries. SCL and SDA are brought into the system clock domain through synchroniser chains. Bus edges and START/STOP conditions are found in that domain. The block answers only to its own fixed 7-bit address and drives SDA through an active-high pull-down enable.

A write transfer works as follows. The master sends the write address. The first byte after it loads the register pointer, and each byte after that is written to the bank at the pointer, which then advances. A read transfer sends bank bytes from the pointer, and the pointer advances after every byte sent. The master sets a read start point by writing the pointer, issuing a repeated START and then sending the read address. If it sends the read address directly, the read starts where the pointer was left.

The register bank sits outside the block on a plain parallel port. The port carries the pointer as address, a one-cycle write strobe with its data, and combinational read data for the address presented.

Top module: `i2c_regfile_target`

## Requirements
- R1: After a START, an address byte of 0xD0 (write) or 0xD1 (read) is acknowledged. Any other address byte is not acknowledged, and the block then neither acknowledges nor writes until the next START.
- R2: In a write transfer, the first byte after the address loads the pointer with only its low 6 bits, so a byte of 0x41 selects register 0x01.
- R3: Each later byte of a write transfer produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then advances by one.
- R4: The pointer wraps from 0x3F to 0x00, and a transfer may carry any number of bytes across the wrap.
- R5: A read address sent straight after START returns bank bytes starting at the current pointer, MSB first. The pointer advances once per byte sent, including the last byte, which the master does not acknowledge.
- R6: A pointer write followed by a repeated START and the read address returns bytes starting at the pointer just written.
- R7: For every received byte it accepts, the block pulls SDA low during the following 9th SCL clock and releases it after that clock's falling edge.
- R8: After the master does not acknowledge a sent byte, the block leaves SDA released, so further clocks read 0xFF, and the pointer is left alone until the next START.
- R9: The pull-down enable and the pointer change only while SCL is low, and after a STOP the pull-down enable is 0.
- R10: Out of reset, `sda_oe` and `reg_we` are 0 and `reg_addr` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 6 | Register pointer, used as bank address |
| reg_wdata | output | 8 | Byte to store, valid with reg_we |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Bank content at reg_addr, combinational |

## Verification
The timing checks compare against raw `scl_i`. They are only valid if each SCL high and low phase lasts well beyond the three-cycle latency of the synchroniser and edge detector. They also assume SDA moves only in the middle of SCL low phases, except for deliberate START and STOP conditions. The stimulus holds each SCL phase for 20 system clocks, and the master changes SDA 10 clocks after SCL falls. The bench's bank model answers reads combinationally, as the port requires.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK_OUT,
      ST_TX,
      ST_ACK_IN,
      ST_IGNORE
   } tgt_state_t;

   typedef enum logic [1:0] {
      BK_ADDR,
      BK_PTR,
      BK_DATA
   } byte_kind_t;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
      logic sda;
   } bus_ev_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RESET_VAL;
      else        chain[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RESET_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2c_tgt_bus_cond.sv
module i2c_tgt_bus_cond
   import i2c_tgt_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_s,
   input  logic    sda_s,
   output bus_ev_t ev
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   // SCL held high across both samples qualifies an SDA change as a condition
   always_comb begin
      ev.scl_rise = scl_s & ~scl_q;
      ev.scl_fall = ~scl_s & scl_q;
      ev.start    = scl_s & scl_q & sda_q & ~sda_s;
      ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
      ev.sda      = sda_s;
   end

endmodule

// File: rtl/i2c_tgt_proto.sv
module i2c_tgt_proto
   import i2c_tgt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 6,
   parameter logic [DATA_W-2:0] DEV_ADDR = 7'h68
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              sda_oe,
   output logic [PTR_W-1:0]  reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   if (DATA_W != 8) begin : g_bad_width
      $error("i2c_tgt_proto: bus bytes are 8 bits");
   end
   if (PTR_W < 1 || PTR_W > DATA_W) begin : g_bad_ptr
      $error("i2c_tgt_proto: pointer must fit in one byte");
   end

   tgt_state_t        state;
   byte_kind_t        kind;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;
   logic [PTR_W-1:0]  ptr;
   logic              rd_dir;
   logic              nack;

   assign reg_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= BK_ADDR;
         cnt       <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         ptr       <= '0;
         rd_dir    <= 1'b0;
         nack      <= 1'b0;
         sda_oe    <= 1'b0;
         reg_wdata <= '0;
         reg_we    <= 1'b0;
      end else begin
         // strobe lasts one cycle; pointer steps as it ends
         if (reg_we) begin
            reg_we <= 1'b0;
            ptr    <= ptr + 1'b1;
         end

         if (ev.start) begin
            state  <= ST_RX;
            kind   <= BK_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (ev.scl_rise && cnt != CNT_FULL) begin
                     rx_sh <= {rx_sh[DATA_W-2:0], ev.sda};
                     cnt   <= cnt + 1'b1;
                  end else if (ev.scl_fall && cnt == CNT_FULL) begin
                     cnt <= '0;
                     case (kind)
                        BK_ADDR: begin
                           if (rx_sh[DATA_W-1:1] == DEV_ADDR) begin
                              rd_dir <= rx_sh[0];
                              state  <= ST_ACK_OUT;
                              sda_oe <= 1'b1;
                           end else begin
                              state <= ST_IGNORE;
                           end
                        end
                        BK_PTR: begin
                           ptr    <= rx_sh[PTR_W-1:0];
                           state  <= ST_ACK_OUT;
                           sda_oe <= 1'b1;
                        end
                        default: begin
                           reg_wdata <= rx_sh;
                           reg_we    <= 1'b1;
                           state     <= ST_ACK_OUT;
                           sda_oe    <= 1'b1;
                        end
                     endcase
                  end
               end

               ST_ACK_OUT: begin
                  if (ev.scl_fall) begin
                     if (kind == BK_ADDR && rd_dir) begin
                        state  <= ST_TX;
                        tx_sh  <= reg_rdata;
                        sda_oe <= ~reg_rdata[DATA_W-1];
                        cnt    <= '0;
                     end else begin
                        state  <= ST_RX;
                        sda_oe <= 1'b0;
                        kind   <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
                     end
                  end
               end

               ST_TX: begin
                  if (ev.scl_fall) begin
                     if (cnt == CNT_LAST) begin
                        sda_oe <= 1'b0;
                        state  <= ST_ACK_IN;
                        ptr    <= ptr + 1'b1;
                     end else begin
                        tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                        sda_oe <= ~tx_sh[DATA_W-2];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end

               ST_ACK_IN: begin
                  if (ev.scl_rise) begin
                     nack <= ev.sda;
                  end else if (ev.scl_fall) begin
                     if (nack) begin
                        state <= ST_IGNORE;
                     end else begin
                        state  <= ST_TX;
                        tx_sh  <= reg_rdata;
                        sda_oe <= ~reg_rdata[DATA_W-1];
                        cnt    <= '0;
                     end
                  end
               end

               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
   import i2c_tgt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PTR_W       = 6,
   parameter int SYNC_STAGES = 2,
   parameter logic [DATA_W-2:0] DEV_ADDR = 7'h68
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [PTR_W-1:0]  reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [DATA_W-1:0] reg_rdata
);

   logic    scl_s;
   logic    sda_s;
   bus_ev_t ev;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_scl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (scl_i),
      .dout  (scl_s)
   );

   i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sda_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sda_i),
      .dout  (sda_s)
   );

   i2c_tgt_bus_cond i_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (scl_s),
      .sda_s (sda_s),
      .ev    (ev)
   );

   i2c_tgt_proto #(
      .DATA_W   (DATA_W),
      .PTR_W    (PTR_W),
      .DEV_ADDR (DEV_ADDR)
   ) i_proto (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .reg_rdata (reg_rdata),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we)
   );

endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk #(
   parameter int PTR_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_i,
   input logic             sda_oe,
   input logic             reg_we,
   input logic [PTR_W-1:0] reg_addr
);

   // R3
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> reg_addr == $past(reg_addr) + 1'b1);

   // R7
   we_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> sda_oe);

   // R9
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // R9
   ptr_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_addr) |-> !scl_i);

endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.PTR_W(PTR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .sda_oe   (sda_oe),
   .reg_we   (reg_we),
   .reg_addr (reg_addr)
);

// File: tb/test_i2c_regfile_target.sv
`timescale 1ns/1ps
module test_i2c_regfile_target;

   localparam int H = 20;
   localparam int Q = 10;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_we;
   logic [7:0] reg_rdata;
   logic       sda_bus;

   int          checks = 0;
   int          fails  = 0;
   int          ref_ptr = 0;
   bit          done = 0;
   logic [7:0]  ref_mem [64];
   logic [7:0]  bank [64];
   logic [13:0] exp_q [$];

   always #2.5 clk = ~clk;

   assign sda_bus   = sda_m & ~sda_oe;
   assign reg_rdata = bank[reg_addr];

   i2c_regfile_target i_i2c_regfile_target (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_bus),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata)
   );

   always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R3: every strobe is compared with the model's next expected write
   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         logic [13:0] e;
         e = (exp_q.size() > 0) ? exp_q[0] : 14'h3fff;
         chk(exp_q.size() > 0 && e == {reg_addr, reg_wdata},
             "R3 write strobe addr/data", {reg_addr, reg_wdata}, e);
         if (exp_q.size() > 0) void'(exp_q.pop_front());
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack, output bit oe_after);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(H);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(H/2);
      ack = !sda_bus;
      tick(H/2);
      scl_m = 1'b0; tick(Q);
      oe_after = sda_oe;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl_m = 1'b1; tick(H/2);
         b[i] = sda_bus;
         tick(H/2);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic model_write(input logic [7:0] d);
      exp_q.push_back({6'(ref_ptr), d});
      ref_mem[ref_ptr] = d;
      ref_ptr = (ref_ptr + 1) % 64;
   endtask

   task automatic wr_xfer(input logic [7:0] pbyte, input logic [7:0] d[$], input string tag);
      bit a, o;
      bus_start();
      send_byte(8'hD0, a, o);
      chk(a, "R1 write address acknowledged", a, 1);
      send_byte(pbyte, a, o);
      chk(a && !o, "R7 pointer byte ack then release", {a, o}, 2);
      ref_ptr = int'(pbyte[5:0]);
      foreach (d[k]) begin
         model_write(d[k]);
         send_byte(d[k], a, o);
         chk(a && !o, {tag, " data byte ack then release (R7)"}, {a, o}, 2);
      end
      bus_stop();
      chk(sda_oe == 1'b0, "R9 released after STOP", sda_oe, 0);
      chk(reg_addr == 6'(ref_ptr), {tag, " pointer after write"}, reg_addr, ref_ptr);
   endtask

   task automatic rd_bytes(input int n, input string tag);
      logic [7:0] b;
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, b);
         chk(b == ref_mem[ref_ptr], {tag, " read byte"}, b, ref_mem[ref_ptr]);
         ref_ptr = (ref_ptr + 1) % 64;
      end
   endtask

   task automatic rd_cur(input int n, input string tag);
      bit a, o;
      bus_start();
      send_byte(8'hD1, a, o);
      chk(a, "R1 read address acknowledged", a, 1);
      rd_bytes(n, tag);
      bus_stop();
      chk(reg_addr == 6'(ref_ptr), {tag, " pointer after read"}, reg_addr, ref_ptr);
   endtask

   task automatic rd_ptr(input logic [7:0] pbyte, input int n, input string tag);
      bit a, o;
      bus_start();
      send_byte(8'hD0, a, o);
      chk(a, "R1 write address acknowledged", a, 1);
      send_byte(pbyte, a, o);
      chk(a, "R2 pointer byte acknowledged", a, 1);
      ref_ptr = int'(pbyte[5:0]);
      bus_start();
      send_byte(8'hD1, a, o);
      chk(a, "R6 read address after repeated START", a, 1);
      rd_bytes(n, tag);
      bus_stop();
      chk(reg_addr == 6'(ref_ptr), {tag, " pointer after read"}, reg_addr, ref_ptr);
   endtask

   initial begin
      logic [7:0] q [$];
      logic [7:0] b;
      bit         a, o;
      int         p0;
      for (int i = 0; i < 64; i++) begin
         bank[i]    = 8'(i * 7 + 3);
         ref_mem[i] = 8'(i * 7 + 3);
      end
      tick(5);
      // R10
      chk(sda_oe == 1'b0 && reg_we == 1'b0 && reg_addr == 6'h00,
          "R10 reset state", {sda_oe, reg_we, reg_addr}, 0);
      rst_n = 1'b1;
      tick(10);

      // R2 R3: pointer then three data bytes
      q = '{8'hA1, 8'hB2, 8'hC3};
      wr_xfer(8'h05, q, "R3");

      // R2: upper pointer bits ignored, 0x41 aliases to 0x01
      q = '{8'h5A};
      wr_xfer(8'h41, q, "R2");

      // R4: wrap across 0x3F
      q = '{8'h11, 8'h22, 8'h33};
      wr_xfer(8'h3E, q, "R4");

      // R6: preset pointer read
      rd_ptr(8'h05, 3, "R6");

      // R5: current-pointer read continues from 0x08
      rd_cur(2, "R5");

      // R1: foreign address ignored until next START
      p0 = int'(reg_addr);
      bus_start();
      send_byte(8'hA0, a, o);
      chk(!a, "R1 foreign address not acknowledged", a, 0);
      send_byte(8'h99, a, o);
      chk(!a, "R1 following byte ignored", a, 0);
      send_byte(8'hD0, a, o);
      chk(!a, "R1 own address without START ignored", a, 0);
      bus_stop();
      chk(reg_addr == 6'(p0), "R1 pointer untouched", reg_addr, p0);

      // R8: NACK releases the bus
      bus_start();
      send_byte(8'hD1, a, o);
      chk(a, "R1 read address acknowledged", a, 1);
      recv_byte(1'b0, b);
      chk(b == ref_mem[ref_ptr], "R8 byte before NACK", b, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % 64;
      recv_byte(1'b0, b);
      chk(b == 8'hFF, "R8 bus released after NACK", b, 8'hFF);
      chk(reg_addr == 6'(ref_ptr), "R8 pointer held after NACK", reg_addr, ref_ptr);
      bus_stop();
      chk(sda_oe == 1'b0, "R9 released after STOP", sda_oe, 0);

      // R4: long transfer past the wrap, then read all 64 back
      q = {};
      for (int k = 0; k < 70; k++) q.push_back(8'(k * 13 + 5));
      wr_xfer(8'h30, q, "R4 long");
      rd_ptr(8'h30, 64, "R4 long");

      tick(20);
      chk(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule